// File: doc/BRIEF.md
# Banked Cursor Shape Memory Port

This block is the host-facing access path to a 1024-byte, two-plane cursor shape store inside a video DAC, plus a wide read port for the video pipeline. The host sees a small register file: an 8-bit in-page index, a byte data window, a full control register and a write path that reaches only the mode field of that control register. The upper address bits are not in the index. Two bank bits in the control register choose one of four 256-byte pages, and pages 2 and 3 make up plane 1.

Each data-window access, read or write, moves the shared index forward by one. It wraps at the page boundary, so a driver can stream a whole page after one index write and then find the index back at zero. A separate video port takes a plane and a row number and returns that row's 64 pixels of one plane one cycle later. Host and video accesses never stall each other.

Top module: `cursor_shape_port`

## Requirements
- R1: After reset the index is 0, the control register (bank and mode) is 0, `cursor_mode` is 00 and `host_rdata` is 0.
- R2: A write with `host_sel`=00 loads `host_wdata` into the index. A read with `host_sel`=00 returns the index on `host_rdata` in the cycle after the read strobe.
- R3: Every data-window access (`host_sel`=01 with `host_wr` or `host_rd`) advances the index by one. The index wraps from 255 to 0, so after 256 data accesses that start at index 0, the index reads 0. Accesses to other registers leave the index unchanged.
- R4: A data-window byte address is bank×256 + index, where bank is control bits [3:2]. Bytes 0–511 form plane 0 and bytes 512–1023 form plane 1.
- R5: A data-window read returns, one cycle after the strobe, the byte at the current address, and it also advances the index. Reads and writes share the one index.
- R6: A write with `host_sel`=10 loads `host_wdata[3:0]` into the control register. A write with `host_sel`=11 loads only bits [1:0] and leaves the bank bits [3:2] unchanged. A read with `host_sel`=10 or 11 returns {4'b0, bank, mode}.
- R7: `cursor_mode` always shows control bits [1:0]: 00 means the cursor is off and 11 means two-colour windowing mode.
- R8: When `vid_en` is high, `vid_data` takes row `vid_row` of plane `vid_plane` on the next clock. A plane is 64 rows of 8 bytes stored row-major. Byte 0 of the row lands in bits [63:56], so bit 63 is the leftmost pixel.
- R9: A host write and a video read in the same cycle both complete without stalling. If the video read covers the byte being written, that byte comes back as either the old or the new value, and every other byte of the row is exact.
- R10: A host strobe with both `host_wr` and `host_rd` high acts as a write only: `host_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for host and video sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 00 index, 01 data window, 10 control, 11 mode field |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| cursor_mode | output | 2 | Current cursor display mode |
| vid_en | input | 1 | Video row fetch request |
| vid_plane | input | 1 | Plane to fetch |
| vid_row | input | 6 | Row to fetch |
| vid_data | output | 64 | Fetched row, leftmost pixel in bit 63 |

## Verification
The whole store is filled page by page through the data window with an address-dependent byte pattern. Every row of both planes is then fetched through the video port, which separates bank decoding errors, plane offset errors and byte-order errors within a row. One page is read back through the host window, and the index is read after each 256-access stream, which exposes wrap faults and read-advance faults. Mode-only writes with bank bits that differ from the stored ones show whether the bank is protected. A write aimed at the row being fetched, alongside neighbouring bytes that are left alone, tests concurrent access.

// File: rtl/csp_pkg.sv
package csp_pkg;
   typedef enum logic [1:0] {
      SEL_INDEX = 2'b00,
      SEL_DATA  = 2'b01,
      SEL_CTRL  = 2'b10,
      SEL_MODE  = 2'b11
   } csp_sel_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/csp_index_ctr.sv
module csp_index_ctr #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] idx
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (load)
         idx <= load_val;
      else if (step)
         idx <= idx + 1'b1;
   end
endmodule

// File: rtl/csp_ctrl_reg.sv
module csp_ctrl_reg #(
   parameter int BANK_W = 2,
   parameter int MODE_W = 2,
   localparam int CTRL_W = BANK_W + MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_we,
   input  logic              mode_we,
   input  logic [CTRL_W-1:0] wdata,
   output logic [BANK_W-1:0] bank,
   output logic [MODE_W-1:0] mode
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank <= '0;
         mode <= '0;
      end else if (full_we) begin
         bank <= wdata[CTRL_W-1:MODE_W];
         mode <= wdata[MODE_W-1:0];
      end else if (mode_we) begin
         mode <= wdata[MODE_W-1:0];
      end
   end
endmodule

// File: rtl/csp_shape_ram.sv
module csp_shape_ram #(
   parameter int ADDR_W    = 10,
   parameter int ROW_BYTES = 8,
   parameter int ROWS      = 64,
   parameter int PLANES    = 2,
   localparam int DEPTH    = 2 ** ADDR_W,
   localparam int PLANE_W  = (PLANES > 1) ? $clog2(PLANES) : 1,
   localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int RB_W     = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1,
   localparam int SLICE_W  = ROW_BYTES * csp_pkg::BYTE_W
) (
   input  logic                       clk,
   input  logic                       host_we,
   input  logic [ADDR_W-1:0]          host_addr,
   input  logic [csp_pkg::BYTE_W-1:0] host_wdata,
   output logic [csp_pkg::BYTE_W-1:0] host_byte,
   input  logic                       vid_en,
   input  logic [PLANE_W-1:0]         vid_plane,
   input  logic [ROW_W-1:0]           vid_row,
   output logic [SLICE_W-1:0]         vid_data
);
   if (PLANE_W + ROW_W + RB_W != ADDR_W) begin : g_bad_geom
      $error("csp_shape_ram: planes*rows*row_bytes must equal the address space");
   end
   if ((2 ** RB_W) != ROW_BYTES || (2 ** ROW_W) != ROWS) begin : g_bad_pow2
      $error("csp_shape_ram: rows and row bytes must be powers of two");
   end

   logic [csp_pkg::BYTE_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0]          row_base;
   logic [SLICE_W-1:0]         row_word;

   assign row_base  = {vid_plane, vid_row, {RB_W{1'b0}}};
   assign host_byte = mem[host_addr];

   for (genvar k = 0; k < ROW_BYTES; k++) begin : g_slice
      assign row_word[(ROW_BYTES-1-k)*csp_pkg::BYTE_W +: csp_pkg::BYTE_W] =
         mem[row_base | ADDR_W'(k)];
   end

   always_ff @(posedge clk) begin
      if (host_we)
         mem[host_addr] <= host_wdata;
   end

   always_ff @(posedge clk) begin
      if (vid_en)
         vid_data <= row_word;
   end
endmodule

// File: rtl/cursor_shape_port.sv
module cursor_shape_port #(
   parameter int IDX_W     = 8,
   parameter int BANK_W    = 2,
   parameter int MODE_W    = 2,
   parameter int ROW_BYTES = 8,
   parameter int ROWS      = 64,
   parameter int PLANES    = 2,
   localparam int ADDR_W   = IDX_W + BANK_W,
   localparam int CTRL_W   = BANK_W + MODE_W,
   localparam int PLANE_W  = (PLANES > 1) ? $clog2(PLANES) : 1,
   localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int SLICE_W  = ROW_BYTES * 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         host_sel,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [7:0]         host_wdata,
   output logic [7:0]         host_rdata,
   output logic [MODE_W-1:0]  cursor_mode,
   input  logic               vid_en,
   input  logic [PLANE_W-1:0] vid_plane,
   input  logic [ROW_W-1:0]   vid_row,
   output logic [SLICE_W-1:0] vid_data
);
   import csp_pkg::*;

   if (IDX_W > BYTE_W || CTRL_W > BYTE_W) begin : g_bad_width
      $error("cursor_shape_port: index and control must fit in a host byte");
   end

   csp_sel_e            sel;
   logic [IDX_W-1:0]    idx;
   logic [BANK_W-1:0]   bank;
   logic [MODE_W-1:0]   mode;
   logic [ADDR_W-1:0]   host_addr;
   logic [BYTE_W-1:0]   mem_byte;
   logic                data_acc;
   logic                rd_only;

   assign sel       = csp_sel_e'(host_sel);
   assign data_acc  = (host_wr || host_rd) && (sel == SEL_DATA);
   assign rd_only   = host_rd && !host_wr;
   assign host_addr = {bank, idx};

   csp_index_ctr #(.IDX_W(IDX_W)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (host_wr && sel == SEL_INDEX),
      .load_val (host_wdata[IDX_W-1:0]),
      .step     (data_acc),
      .idx      (idx)
   );

   csp_ctrl_reg #(.BANK_W(BANK_W), .MODE_W(MODE_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .full_we (host_wr && sel == SEL_CTRL),
      .mode_we (host_wr && sel == SEL_MODE),
      .wdata   (host_wdata[CTRL_W-1:0]),
      .bank    (bank),
      .mode    (mode)
   );

   csp_shape_ram #(
      .ADDR_W    (ADDR_W),
      .ROW_BYTES (ROW_BYTES),
      .ROWS      (ROWS),
      .PLANES    (PLANES)
   ) u_ram (
      .clk        (clk),
      .host_we    (host_wr && sel == SEL_DATA),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_byte  (mem_byte),
      .vid_en     (vid_en),
      .vid_plane  (vid_plane),
      .vid_row    (vid_row),
      .vid_data   (vid_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         host_rdata <= '0;
      else if (rd_only) begin
         unique case (sel)
            SEL_INDEX: host_rdata <= BYTE_W'(idx);
            SEL_DATA:  host_rdata <= mem_byte;
            default:   host_rdata <= BYTE_W'({bank, mode});
         endcase
      end
   end

   assign cursor_mode = mode;
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
   parameter int IDX_W  = 8,
   parameter int BANK_W = 2,
   parameter int MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        host_sel,
   input logic              host_wr,
   input logic              host_rd,
   input logic [7:0]        host_wdata,
   input logic [7:0]        host_rdata,
   input logic [IDX_W-1:0]  idx,
   input logic [BANK_W-1:0] bank,
   input logic [MODE_W-1:0] cursor_mode
);
   logic [IDX_W-1:0] idx_inc;
   assign idx_inc = idx + 1'b1;

   // R2
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == 2'b00) |=> idx == $past(host_wdata[IDX_W-1:0]));

   // R3
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_wr || host_rd) && host_sel == 2'b01) |=> idx == $past(idx_inc));

   // R3
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(host_wr || host_rd) || host_sel[1]) |=> $stable(idx));

   // R6
   bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == 2'b11) |=> $stable(bank));

   // R7
   mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel[1]) |=> cursor_mode == $past(host_wdata[MODE_W-1:0]));

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr || !host_rd) |=> $stable(host_rdata));
endmodule

bind cursor_shape_port csp_checker #(
   .IDX_W  (IDX_W),
   .BANK_W (BANK_W),
   .MODE_W (MODE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_sel    (host_sel),
   .host_wr     (host_wr),
   .host_rd     (host_rd),
   .host_wdata  (host_wdata),
   .host_rdata  (host_rdata),
   .idx         (idx),
   .bank        (bank),
   .cursor_mode (cursor_mode)
);

// File: tb/cursor_shape_port_tb.sv
module cursor_shape_port_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  host_sel = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [1:0]  cursor_mode;
   logic        vid_en = 1'b0;
   logic [0:0]  vid_plane = '0;
   logic [5:0]  vid_row = '0;
   logic [63:0] vid_data;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cursor_shape_port u_dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cursor_mode(cursor_mode), .vid_en(vid_en), .vid_plane(vid_plane),
      .vid_row(vid_row), .vid_data(vid_data)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) ^ (a >> 5));
   endfunction

   function automatic logic [63:0] exp_row(input int p, input int r);
      logic [63:0] w;
      for (int k = 0; k < 8; k++) w[(7-k)*8 +: 8] = pat(p*512 + r*8 + k);
      return w;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      host_sel = s; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      host_sel = s; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic vread(input int p, input int r, output logic [63:0] d);
      @(negedge clk);
      vid_plane = 1'(p); vid_row = 6'(r); vid_en = 1'b1;
      @(negedge clk);
      vid_en = 1'b0;
      d = vid_data;
   endtask

   initial begin
      logic [7:0]  b;
      logic [63:0] w;
      bit          bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rdata", 64'(host_rdata), 64'h0);
      check("R1 mode", 64'(cursor_mode), 64'h0);
      hread(2'b00, b); check("R1 index", 64'(b), 64'h0);
      hread(2'b10, b); check("R1 ctrl", 64'(b), 64'h0);

      // R2 index load / read back
      hwrite(2'b00, 8'hA5);
      hread(2'b00, b); check("R2 index readback", 64'(b), 64'hA5);

      // R4 fill every page through the window
      for (int pg = 0; pg < 4; pg++) begin
         hwrite(2'b10, 8'(pg << 2));
         hwrite(2'b00, 8'h00);
         for (int i = 0; i < 256; i++) hwrite(2'b01, pat(pg*256 + i));
         hread(2'b00, b); check("R3 wrap after 256 writes", 64'(b), 64'h0);
      end

      // R8 / R4 every row of both planes
      bad = 1'b0;
      for (int p = 0; p < 2; p++)
         for (int r = 0; r < 64; r++) begin
            vread(p, r, w);
            if (w !== exp_row(p, r)) begin
               bad = 1'b1;
               $display("FAIL R8 row p%0d r%0d: actual %h expected %h", p, r, w, exp_row(p, r));
            end
         end
      check("R8 R4 row sweep", 64'(bad), 64'h0);

      // R5 read back page 1 via host window, index starting mid-page
      hwrite(2'b10, 8'h04);
      hwrite(2'b00, 8'hF0);
      bad = 1'b0;
      for (int i = 0; i < 256; i++) begin
         hread(2'b01, b);
         if (b !== pat(256 + ((240 + i) % 256))) begin
            bad = 1'b1;
            $display("FAIL R5 byte %0d: actual %h expected %h", i, b, pat(256 + ((240 + i) % 256)));
         end
      end
      check("R5 page readback", 64'(bad), 64'h0);
      hread(2'b00, b); check("R3 index after 256 reads", 64'(b), 64'hF0);

      // R3 mixed read/write share index; other registers do not move it
      hwrite(2'b00, 8'hFE);
      hread(2'b01, b);
      hread(2'b10, b);
      hwrite(2'b11, 8'h00);
      hread(2'b00, b); check("R3 index step/hold", 64'(b), 64'hFF);
      hwrite(2'b01, 8'h3C);
      hread(2'b00, b); check("R3 wrap 255->0", 64'(b), 64'h00);
      vread(0, 63, w);
      check("R4 byte 0x1FF", 64'(w[7:0]), 64'h3C);

      // R6 / R7 mode field vs bank
      hwrite(2'b10, 8'h0B);
      check("R7 mode after full write", 64'(cursor_mode), 64'h3);
      hwrite(2'b11, 8'hFC);
      hread(2'b10, b); check("R6 mode-only write keeps bank", 64'(b), 64'h08);
      check("R7 mode off", 64'(cursor_mode), 64'h0);
      hwrite(2'b11, 8'h03);
      hread(2'b11, b); check("R6 ctrl read via mode sel", 64'(b), 64'h0B);
      check("R7 windowing mode", 64'(cursor_mode), 64'h3);

      // R9 concurrent host write + video read of the same row (bank 2 = plane 1 rows 0..31)
      hwrite(2'b00, 8'h12);           // byte 0x212 -> plane 1 row 2 byte 2
      @(negedge clk);
      host_sel = 2'b01; host_wdata = 8'hC3; host_wr = 1'b1;
      vid_plane = 1'b1; vid_row = 6'd2; vid_en = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; vid_en = 1'b0;
      w = vid_data;
      check("R9 other bytes exact", {w[63:48], w[39:0]}, {exp_row(1,2)[63:48], exp_row(1,2)[39:0]});
      check("R9 target old or new", 64'((w[47:40] == 8'hC3) || (w[47:40] == pat(512+16+2))), 64'h1);
      vread(1, 2, w);
      check("R9 new value landed", 64'(w[47:40]), 64'hC3);

      // R10 write+read together acts as write only
      hread(2'b00, b);                // rdata = 0x13
      @(negedge clk);
      host_sel = 2'b00; host_wdata = 8'h44; host_wr = 1'b1; host_rd = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      check("R10 rdata held", 64'(host_rdata), 64'h13);
      hread(2'b00, b); check("R10 write took effect", 64'(b), 64'h44);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule